// File: doc/BRIEF.md
# Segmented Page Translation Cache

This block turns a 32-bit effective address into a real address for 4 KB pages. A bank of sixteen segment registers sits in front of a 64-slot direct-mapped cache. The top four address bits pick a segment register, which supplies a 24-bit virtual segment identifier, two protection keys and a no-execute flag. Six page-number bits pick one cache slot. The slot hits only when its stored segment identifier and its stored sixteen-bit page number both match the current access.

A lookup is combinational on the registered state. It reports a hit, the real address, a protection violation, an unsupported-segment error and a request to set the change bit in the page-table entry. A page-table walker outside this block loads slots through the fill port. The memory system acknowledges change-bit requests. Invalidation can clear one slot, selected by address, or every slot at once.

Top module: `page_xlate_cache`

## Requirements
- R1: A segment register is written as a 32-bit word with an unsupported-format flag in bit 31, the supervisor key in bit 30, the user key in bit 29, no-execute in bit 28 and the segment identifier in bits [23:0]. The register is selected by EA[31:28]. A valid lookup through a register whose bit 31 is set raises `lk_seg_err` and never hits.
- R2: The cache slot is EA[17:12]. A lookup hits only if the slot holds the segment's identifier and EA[27:12]. After reset no lookup hits.
- R3: On a hit, `lk_ra` is the slot's 20-bit real page number above EA[11:0].
- R4: `lk_kind` is coded 00 read, 01 write, 10 instruction fetch and 11 treated as read. The key is the user key when `lk_user` is 1 and the supervisor key otherwise. With key 0, only PP=11 refuses writes. With key 1, PP=00 refuses every access, PP=01 and PP=11 refuse writes, and PP=10 allows all. A refused access on a hit raises `lk_prot_err`.
- R5: An instruction fetch through a segment with no-execute set is a protection violation. Otherwise a fetch is judged as a read.
- R6: `lk_chg_req` is 1 exactly when a permitted write hits a slot whose cached change bit is 0. In that case `lk_chg_addr` carries the slot's stored address of the second page-table word.
- R7: A request stays up until `chg_ack` is seen with it. From the next cycle the slot's cached change bit is 1 and the same write makes no further request.
- R8: `inv_one` clears only the slot picked by `inv_ea[17:12]`, whatever the other address bits are. Other slots keep hitting.
- R9: `inv_all` clears every slot.
- R10: When a fill and an invalidation address the same slot in one cycle, the invalidation wins. A fill to a different slot in that cycle still takes effect.
- R11: With `lk_valid` at 0, `lk_hit`, `lk_seg_err`, `lk_prot_err` and `lk_chg_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_sel | input | 4 | Segment register number |
| seg_wdata | input | 32 | Segment register value |
| lk_valid | input | 1 | Lookup present |
| lk_ea | input | 32 | Lookup effective address |
| lk_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch) |
| lk_user | input | 1 | Problem (user) state |
| lk_hit | output | 1 | Slot match |
| lk_seg_err | output | 1 | Segment format unsupported |
| lk_prot_err | output | 1 | Protection violation on hit |
| lk_ra | output | 32 | Real address (0 on miss) |
| lk_chg_req | output | 1 | Change-bit write-back request |
| lk_chg_addr | output | 32 | Address of the second page-table word |
| chg_ack | input | 1 | Change-bit request accepted |
| fill_valid | input | 1 | Fill strobe from walker |
| fill_ea | input | 32 | Effective address being filled |
| fill_pp | input | 2 | Page protection bits |
| fill_chg | input | 1 | Change bit from the page-table entry |
| fill_rpn | input | 20 | Real page number |
| fill_ptea | input | 32 | Address of the second page-table word |
| inv_one | input | 1 | Invalidate slot selected by inv_ea |
| inv_ea | input | 32 | Address selecting the slot to invalidate |
| inv_all | input | 1 | Invalidate all slots |

## Verification
A fill and an invalidation can arrive in the same cycle. A change-bit acknowledge can also land on a slot that the walker refills in that cycle. The bench drives a fill and `inv_one` to the same slot in one cycle and then looks up that slot, which must miss. It repeats this with the invalidation aimed at a different slot, where the fill must hit, and with `inv_all` alongside a fill, where the fill must miss. The acknowledge path is judged by looking up the same write in the following cycle: the hit remains, and no new change request appears.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    localparam logic [1:0] PP_NONE = 2'b00;
    localparam logic [1:0] PP_RW   = 2'b10;
    localparam logic [1:0] PP_RO   = 2'b11;
endpackage

// File: rtl/pxc_seg_file.sv
module pxc_seg_file #(
    parameter int SEL_W  = 4,
    parameter int VSID_W = 24,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  a_sel,
    output logic              a_fmt,
    output logic              a_ksup,
    output logic              a_kusr,
    output logic              a_noexec,
    output logic [VSID_W-1:0] a_vsid,
    input  logic [SEL_W-1:0]  b_sel,
    output logic [VSID_W-1:0] b_vsid
);
    localparam int SEGS = 2 ** SEL_W;

    typedef struct packed {
        logic              fmt;
        logic              ksup;
        logic              kusr;
        logic              noexec;
        logic [VSID_W-1:0] vsid;
    } seg_t;

    seg_t [SEGS-1:0] seg_d, seg_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[WORD_W-5:VSID_W];

    always_comb begin
        seg_d = seg_q;
        if (wr_en) begin
            seg_d[wr_sel] = {wr_data[WORD_W-1], wr_data[WORD_W-2],
                             wr_data[WORD_W-3], wr_data[WORD_W-4],
                             wr_data[VSID_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end

    assign a_fmt    = seg_q[a_sel].fmt;
    assign a_ksup   = seg_q[a_sel].ksup;
    assign a_kusr   = seg_q[a_sel].kusr;
    assign a_noexec = seg_q[a_sel].noexec;
    assign a_vsid   = seg_q[a_sel].vsid;
    assign b_vsid   = seg_q[b_sel].vsid;
endmodule

// File: rtl/pxc_prot_check.sv
module pxc_prot_check
    import pxc_pkg::*;
(
    input  logic       ksup,
    input  logic       kusr,
    input  logic       user,
    input  logic       noexec,
    input  logic [1:0] pp,
    input  logic [1:0] kind,
    output logic       violation
);
    logic key;
    logic deny_all;
    logic deny_write;

    always_comb begin
        key        = user ? kusr : ksup;
        deny_all   = key && (pp == PP_NONE);
        deny_write = key ? (pp != PP_RW) : (pp == PP_RO);
        case (acc_kind_e'(kind))
            ACC_WRITE: violation = deny_write;
            ACC_FETCH: violation = deny_all || noexec;
            default:   violation = deny_all;
        endcase
    end
endmodule

// File: rtl/page_xlate_cache.sv
module page_xlate_cache
    import pxc_pkg::*;
#(
    parameter int EA_W       = 32,
    parameter int SEG_SEL_W  = 4,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 6,
    parameter int VSID_W     = 24,
    parameter int RPN_W      = 20,
    parameter int PTEA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          seg_we,
    input  logic [SEG_SEL_W-1:0]          seg_sel,
    input  logic [31:0]                   seg_wdata,
    input  logic                          lk_valid,
    input  logic [EA_W-1:0]               lk_ea,
    input  logic [1:0]                    lk_kind,
    input  logic                          lk_user,
    output logic                          lk_hit,
    output logic                          lk_seg_err,
    output logic                          lk_prot_err,
    output logic [RPN_W+PAGE_SHIFT-1:0]   lk_ra,
    output logic                          lk_chg_req,
    output logic [PTEA_W-1:0]             lk_chg_addr,
    input  logic                          chg_ack,
    input  logic                          fill_valid,
    input  logic [EA_W-1:0]               fill_ea,
    input  logic [1:0]                    fill_pp,
    input  logic                          fill_chg,
    input  logic [RPN_W-1:0]              fill_rpn,
    input  logic [PTEA_W-1:0]             fill_ptea,
    input  logic                          inv_one,
    input  logic [EA_W-1:0]               inv_ea,
    input  logic                          inv_all
);
    localparam int NUM_ENTRIES = 2 ** IDX_W;
    localparam int PN_W        = EA_W - SEG_SEL_W - PAGE_SHIFT;
    localparam int TAG_W       = VSID_W + 1;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [PN_W-1:0]   page;
        logic [1:0]        pp;
        logic              chg;
        logic [RPN_W-1:0]  rpn;
        logic [PTEA_W-1:0] ptea;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_ENTRIES-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    logic [SEG_SEL_W-1:0] lk_seg, fill_seg;
    logic [IDX_W-1:0]     lk_idx, fill_idx, inv_idx;
    logic [PN_W-1:0]      lk_page, fill_page;
    logic                 sa_fmt, sa_ksup, sa_kusr, sa_noexec;
    logic [VSID_W-1:0]    sa_vsid, sb_vsid;
    entry_t               cur;
    logic                 tag_match;
    logic                 viol;
    logic                 chg_fire;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{fill_ea[PAGE_SHIFT-1:0],
                                inv_ea[EA_W-1:PAGE_SHIFT+IDX_W],
                                inv_ea[PAGE_SHIFT-1:0]};

    assign lk_seg    = lk_ea[EA_W-1 -: SEG_SEL_W];
    assign fill_seg  = fill_ea[EA_W-1 -: SEG_SEL_W];
    assign lk_idx    = lk_ea[PAGE_SHIFT +: IDX_W];
    assign fill_idx  = fill_ea[PAGE_SHIFT +: IDX_W];
    assign inv_idx   = inv_ea[PAGE_SHIFT +: IDX_W];
    assign lk_page   = lk_ea[PAGE_SHIFT +: PN_W];
    assign fill_page = fill_ea[PAGE_SHIFT +: PN_W];

    pxc_seg_file #(
        .SEL_W  (SEG_SEL_W),
        .VSID_W (VSID_W),
        .WORD_W (32)
    ) i_segs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (seg_we),
        .wr_sel   (seg_sel),
        .wr_data  (seg_wdata),
        .a_sel    (lk_seg),
        .a_fmt    (sa_fmt),
        .a_ksup   (sa_ksup),
        .a_kusr   (sa_kusr),
        .a_noexec (sa_noexec),
        .a_vsid   (sa_vsid),
        .b_sel    (fill_seg),
        .b_vsid   (sb_vsid)
    );

    assign cur       = st_q.ent[lk_idx];
    assign tag_match = (cur.tag == {1'b0, sa_vsid}) && (cur.page == lk_page);

    pxc_prot_check i_prot (
        .ksup      (sa_ksup),
        .kusr      (sa_kusr),
        .user      (lk_user),
        .noexec    (sa_noexec),
        .pp        (cur.pp),
        .kind      (lk_kind),
        .violation (viol)
    );

    always_comb begin
        lk_seg_err  = lk_valid && sa_fmt;
        lk_hit      = lk_valid && !sa_fmt && tag_match;
        lk_prot_err = lk_hit && viol;
        lk_ra       = lk_hit ? {cur.rpn, lk_ea[PAGE_SHIFT-1:0]} : '0;
        lk_chg_req  = lk_hit && !viol && (lk_kind == ACC_WRITE) && !cur.chg;
        lk_chg_addr = lk_chg_req ? cur.ptea : '0;
        chg_fire    = lk_chg_req && chg_ack;
    end

    // next state: lowest priority first, later statements override
    always_comb begin
        st_d = st_q;
        if (chg_fire) begin
            st_d.ent[lk_idx].chg = 1'b1;
        end
        if (fill_valid) begin
            st_d.ent[fill_idx].tag  = {1'b0, sb_vsid};
            st_d.ent[fill_idx].page = fill_page;
            st_d.ent[fill_idx].pp   = fill_pp;
            st_d.ent[fill_idx].chg  = fill_chg;
            st_d.ent[fill_idx].rpn  = fill_rpn;
            st_d.ent[fill_idx].ptea = fill_ptea;
        end
        if (inv_one) begin
            st_d.ent[inv_idx].tag = '1;
        end
        if (inv_all) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                st_d.ent[i].tag = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                st_q.ent[i]     <= '0;
                st_q.ent[i].tag <= '1;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
    parameter int EA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 6,
    parameter int RA_W       = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [EA_W-1:0] lk_ea,
    input logic [1:0]      lk_kind,
    input logic            lk_hit,
    input logic            lk_seg_err,
    input logic            lk_prot_err,
    input logic [RA_W-1:0] lk_ra,
    input logic            lk_chg_req,
    input logic            chg_ack,
    input logic            fill_valid,
    input logic            inv_one,
    input logic [EA_W-1:0] inv_ea,
    input logic            inv_all
);
    a_r1_bad_segment_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_seg_err |-> !lk_hit);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_seg_err && !lk_prot_err && !lk_chg_req));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_ra[PAGE_SHIFT-1:0] == lk_ea[PAGE_SHIFT-1:0]));

    a_r6_req_only_allowed_write: assert property (@(posedge clk) disable iff (!rst_n)
        lk_chg_req |-> (lk_hit && !lk_prot_err && lk_kind == 2'b01));

    a_r7_req_once: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_chg_req && chg_ack && !fill_valid)
        |=> !(lk_chg_req && lk_ea == $past(lk_ea)));

    a_r8_slot_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        inv_one |=> !(lk_hit && lk_ea[PAGE_SHIFT +: IDX_W] == $past(inv_ea[PAGE_SHIFT +: IDX_W])));

    a_r9_all_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !lk_hit);
endmodule

bind page_xlate_cache pxc_checker #(
    .EA_W       (EA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .IDX_W      (IDX_W),
    .RA_W       (RPN_W + PAGE_SHIFT)
) i_pxc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_ea       (lk_ea),
    .lk_kind     (lk_kind),
    .lk_hit      (lk_hit),
    .lk_seg_err  (lk_seg_err),
    .lk_prot_err (lk_prot_err),
    .lk_ra       (lk_ra),
    .lk_chg_req  (lk_chg_req),
    .chg_ack     (chg_ack),
    .fill_valid  (fill_valid),
    .inv_one     (inv_one),
    .inv_ea      (inv_ea),
    .inv_all     (inv_all)
);

// File: tb/test_page_xlate_cache.sv
`timescale 1ns/1ps
module test_page_xlate_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_sel = '0;
    logic [31:0] seg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_seg_err, lk_prot_err, lk_chg_req;
    logic [31:0] lk_ra, lk_chg_addr;
    logic        chg_ack = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_ea = '0;
    logic [1:0]  fill_pp = '0;
    logic        fill_chg = 1'b0;
    logic [19:0] fill_rpn = '0;
    logic [31:0] fill_ptea = '0;
    logic        inv_one = 1'b0;
    logic [31:0] inv_ea = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    page_xlate_cache i_page_xlate_cache (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ea(input int seg, input int idx, input int hi, input int off);
        return {seg[3:0], hi[9:0], idx[5:0], off[11:0]};
    endfunction

    function automatic logic [31:0] seg_word(input bit t, input bit ks, input bit kp,
                                             input bit nx, input logic [23:0] vsid);
        return {t, ks, kp, nx, 4'b0, vsid};
    endfunction

    task automatic seg_wr(input int s, input logic [31:0] v);
        seg_we = 1'b1; seg_sel = s[3:0]; seg_wdata = v;
        tick();
        seg_we = 1'b0;
    endtask

    task automatic fill_drive(input logic [31:0] ea, input logic [1:0] pp, input bit chg,
                              input logic [19:0] rpn, input logic [31:0] ptea);
        fill_valid = 1'b1; fill_ea = ea; fill_pp = pp; fill_chg = chg;
        fill_rpn = rpn; fill_ptea = ptea;
    endtask

    task automatic fill(input logic [31:0] ea, input logic [1:0] pp, input bit chg,
                        input logic [19:0] rpn, input logic [31:0] ptea);
        fill_drive(ea, pp, chg, rpn, ptea);
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] ea, input logic [1:0] kind, input bit user);
        lk_valid = 1'b1; lk_ea = ea; lk_kind = kind; lk_user = user;
        #1;
    endtask

    function automatic bit denied(input bit ks, input bit kp, input bit nx, input bit user,
                                  input logic [1:0] pp, input logic [1:0] kind);
        bit key = user ? kp : ks;
        bit no_read  = key && pp == 2'b00;
        bit no_write = key ? (pp != 2'b10) : (pp == 2'b11);
        if (kind == 2'b01) return no_write;
        if (kind == 2'b10) return no_read || nx;
        return no_read;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2: nothing hits after reset
        for (int i = 0; i < 64; i += 9) begin
            look(mk_ea(i % 16, i, 0, 0), 2'b00, 1'b0);
            chk("R2 reset miss", lk_hit, 0);
        end
        lk_valid = 1'b0;

        for (int s = 0; s < 16; s++) seg_wr(s, seg_word(0, 0, 0, 0, 24'h100 + 24'(s)));

        // R2/R3: fill every slot then read each back
        for (int i = 0; i < 64; i++)
            fill(mk_ea(i % 16, i, i * 7, 0), 2'b10, 1'b1, 20'hA0000 + 20'(i * 3), 32'h8000_0000 + 32'(i * 8));
        for (int i = 0; i < 64; i++) begin
            look(mk_ea(i % 16, i, i * 7, i * 37), 2'b00, 1'b0);
            chk("R2 filled hit", lk_hit, 1);
            chk("R3 real address", lk_ra, {20'hA0000 + 20'(i * 3), 12'(i * 37)});
            look(mk_ea(i % 16, i, i * 7 + 1, 0), 2'b00, 1'b0);
            chk("R2 page tag mismatch", lk_hit, 0);
        end
        lk_valid = 1'b0;
        seg_wr(0, seg_word(0, 0, 0, 0, 24'h777));
        look(mk_ea(0, 16, 16 * 7, 0), 2'b00, 1'b0);
        chk("R2 segment id mismatch", lk_hit, 0);
        lk_valid = 1'b0;
        seg_wr(0, seg_word(0, 0, 0, 0, 24'h100));
        look(mk_ea(0, 16, 16 * 7, 0), 2'b00, 1'b0);
        chk("R2 segment id restored", lk_hit, 1);

        // R1: unsupported segment format
        lk_valid = 1'b0;
        seg_wr(15, seg_word(1, 0, 0, 0, 24'h10F));
        look(mk_ea(15, 15, 15 * 7, 0), 2'b00, 1'b0);
        chk("R1 seg err", lk_seg_err, 1);
        chk("R1 no hit", lk_hit, 0);
        look(mk_ea(14, 14, 14 * 7, 0), 2'b00, 1'b0);
        chk("R1 other seg ok", {lk_seg_err, lk_hit}, 2'b01);
        lk_valid = 1'b0;
        seg_wr(15, seg_word(0, 0, 0, 0, 24'h10F));

        // R11: lookup not valid
        look(mk_ea(3, 3, 21, 0), 2'b01, 1'b0);
        lk_valid = 1'b0;
        #1;
        chk("R11 idle quiet", {lk_hit, lk_seg_err, lk_prot_err, lk_chg_req}, 0);

        // R4/R5: exhaustive protection sweep
        for (int pp = 0; pp < 4; pp++) begin
            fill(mk_ea(3, 5, 99, 0), 2'(pp), 1'b1, 20'h12345, 32'h0);
            for (int f = 0; f < 8; f++) begin
                seg_wr(3, seg_word(0, f[2], f[1], f[0], 24'hABC123));
                fill(mk_ea(3, 5, 99, 0), 2'(pp), 1'b1, 20'h12345, 32'h0);
                for (int u = 0; u < 2; u++) begin
                    for (int k = 0; k < 4; k++) begin
                        look(mk_ea(3, 5, 99, 0), 2'(k), u[0]);
                        chk("R4 hit", lk_hit, 1);
                        if (k == 2)
                            chk("R5 fetch protection", lk_prot_err,
                                denied(f[2], f[1], f[0], u[0], 2'(pp), 2'(k)));
                        else
                            chk("R4 key/pp protection", lk_prot_err,
                                denied(f[2], f[1], f[0], u[0], 2'(pp), 2'(k)));
                    end
                end
                lk_valid = 1'b0;
            end
        end

        // R6/R7: change-bit write-back
        seg_wr(5, seg_word(0, 0, 0, 0, 24'h555));
        fill(mk_ea(5, 20, 3, 0), 2'b10, 1'b0, 20'h0BEEF, 32'h1234_5678);
        look(mk_ea(5, 20, 3, 4), 2'b00, 1'b0);
        chk("R6 read no request", lk_chg_req, 0);
        look(mk_ea(5, 20, 3, 4), 2'b01, 1'b0);
        chk("R6 write request", lk_chg_req, 1);
        chk("R6 request address", lk_chg_addr, 32'h1234_5678);
        tick();
        chk("R7 held until ack", lk_chg_req, 1);
        chg_ack = 1'b1;
        tick();
        chg_ack = 1'b0;
        #1;
        chk("R7 no repeat", lk_chg_req, 0);
        chk("R7 still hits", lk_hit, 1);
        lk_valid = 1'b0;
        fill(mk_ea(5, 20, 3, 0), 2'b11, 1'b0, 20'h0BEEF, 32'h1234_5678);
        look(mk_ea(5, 20, 3, 4), 2'b01, 1'b0);
        chk("R6 denied write no request", {lk_prot_err, lk_chg_req}, 2'b10);
        lk_valid = 1'b0;

        // R8: single invalidate
        fill(mk_ea(5, 10, 1, 0), 2'b10, 1'b1, 20'h1, 32'h0);
        fill(mk_ea(5, 11, 1, 0), 2'b10, 1'b1, 20'h2, 32'h0);
        inv_one = 1'b1; inv_ea = mk_ea(9, 10, 500, 123);
        tick();
        inv_one = 1'b0;
        look(mk_ea(5, 10, 1, 0), 2'b00, 1'b0);
        chk("R8 slot cleared", lk_hit, 0);
        look(mk_ea(5, 11, 1, 0), 2'b00, 1'b0);
        chk("R8 neighbour kept", lk_hit, 1);
        lk_valid = 1'b0;

        // R10: fill and invalidate in one cycle
        fill_drive(mk_ea(5, 10, 1, 0), 2'b10, 1'b1, 20'h3, 32'h0);
        inv_one = 1'b1; inv_ea = mk_ea(0, 10, 0, 0);
        tick();
        fill_valid = 1'b0; inv_one = 1'b0;
        look(mk_ea(5, 10, 1, 0), 2'b00, 1'b0);
        chk("R10 invalidate beats fill", lk_hit, 0);
        lk_valid = 1'b0;
        fill_drive(mk_ea(5, 12, 1, 0), 2'b10, 1'b1, 20'h4, 32'h0);
        inv_one = 1'b1; inv_ea = mk_ea(0, 11, 0, 0);
        tick();
        fill_valid = 1'b0; inv_one = 1'b0;
        look(mk_ea(5, 12, 1, 0), 2'b00, 1'b0);
        chk("R10 other slot fill lands", lk_hit, 1);
        look(mk_ea(5, 11, 1, 0), 2'b00, 1'b0);
        chk("R10 other slot invalidated", lk_hit, 0);
        lk_valid = 1'b0;
        fill_drive(mk_ea(5, 13, 1, 0), 2'b10, 1'b1, 20'h5, 32'h0);
        inv_all = 1'b1;
        tick();
        fill_valid = 1'b0; inv_all = 1'b0;
        look(mk_ea(5, 13, 1, 0), 2'b00, 1'b0);
        chk("R10 flush beats fill", lk_hit, 0);

        // R9: flush everything
        for (int i = 0; i < 64; i++) begin
            look(mk_ea(i % 16, i, i * 7, 0), 2'b00, 1'b0);
            chk("R9 flushed", lk_hit, 0);
        end
        lk_valid = 1'b0;

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule